// File: doc/BRIEF.md
# Color-Key Pixel Source Switch

For every pixel, this block chooses between two sources: a direct-color pixel and an alternate pixel, which may be true-color or overlay graphics. It makes the choice by checking the raw red, green, blue and overlay fields of the incoming pixel against programmable windows. Each window has an inclusive low bound and an inclusive high bound.

Each of the four channel comparators can be switched on or off on its own. The key is asserted when every enabled comparator reports a hit. A polarity bit can invert the key before it drives the multiplexer. The chosen pixel and a flag that marks the alternate source are both registered, so they appear one pixel clock after the inputs.

A simple write port programs eight 8-bit window bounds and one control byte. These sit at consecutive addresses starting from a base address set by a parameter.

Top module: `ckey_switch`

## Requirements
- R1: While reset is held and right after it is released, `pix_o` and `alt_sel_o` are 0, all window bounds are 0 and every comparator is disabled with polarity not inverted.
- R2: Addresses are counted as offsets from `BASE`. Offsets 0 and 1 hold the red low and high bounds, 2 and 3 the green bounds, 4 and 5 the blue bounds, and 6 and 7 the overlay bounds. Offset 8 is the control byte: bit 0 enables red, bit 1 green, bit 2 blue, bit 3 overlay, and bit 4 inverts polarity. A write to any other address changes nothing.
- R3: A channel hits when low <= value <= high, with both bounds inclusive. When low > high, the channel never hits.
- R4: The key is true only when every enabled channel hits. Disabled channels are ignored.
- R5: When no comparator is enabled, the direct pixel is always selected, whatever the polarity bit says.
- R6: When at least one comparator is enabled and the polarity bit is 1, the selection is the inverse of the key.
- R7: When `alt_sel_o` is 1, `pix_o` equals the alternate pixel. When it is 0, `pix_o` equals the direct pixel, in both cases taken from the same input cycle.
- R8: The selection is made for each pixel on its own, with a latency of exactly one clock.
- R9: A register write takes effect for pixels sampled on the clock edge after the write edge. A pixel presented in the same cycle as a write still uses the old settings.
- R10: The overlay field is compared in exactly the same way as the color fields. It can key the switch even when it is the only channel enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | CW | Register write data |
| red_i | input | CW | Raw red field |
| grn_i | input | CW | Raw green field |
| blu_i | input | CW | Raw blue field |
| ovl_i | input | CW | Overlay field |
| dir_pix_i | input | PW | Direct-color pixel |
| alt_pix_i | input | PW | Alternate pixel |
| pix_o | output | PW | Selected pixel, registered |
| alt_sel_o | output | 1 | 1 when the alternate pixel was selected |

## Verification
The bench drives values exactly at each bound and one step outside it. A design with an off-by-one comparison would then switch on the wrong pixel. It also programs an empty window where low exceeds high, and a design that swapped the order of the bounds would hit inside that window.

It sets the polarity bit with every comparator off. A design that inverted the key before gating on the enables would show the alternate source on the whole screen.

It writes to addresses just outside the map, and writes the control byte in the same cycle as a pixel. An address decoder that aliases would corrupt a bound, and a design that bypassed the register would apply the new setting one pixel too early.

// File: rtl/ckey_pkg.sv
package ckey_pkg;
  localparam int NCH = 4;
  // channel order inside packed arrays and the register map
  localparam int CH_RED = 0;
  localparam int CH_GRN = 1;
  localparam int CH_BLU = 2;
  localparam int CH_OVL = 3;
  localparam int CTRL_OFS = 2 * NCH;
  localparam int INV_BIT = NCH;
endpackage

// File: rtl/ckey_regs.sv
module ckey_regs
  import ckey_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = 8'h30
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [CW-1:0]           wr_data_i,
  output logic [NCH-1:0][CW-1:0]  lo_o,
  output logic [NCH-1:0][CW-1:0]  hi_o,
  output logic [NCH-1:0]          en_o,
  output logic                    inv_o
);
  localparam logic [AW-1:0] CTRL_ADDR = BASE + AW'(CTRL_OFS);

  for (genvar c = 0; c < NCH; c++) begin : g_win
    localparam logic [AW-1:0] LO_ADDR = BASE + AW'(2 * c);
    localparam logic [AW-1:0] HI_ADDR = BASE + AW'(2 * c + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_o[c] <= '0;
        hi_o[c] <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == LO_ADDR) lo_o[c] <= wr_data_i;
        if (wr_addr_i == HI_ADDR) hi_o[c] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      inv_o <= 1'b0;
    end else if (wr_en_i && wr_addr_i == CTRL_ADDR) begin
      en_o  <= wr_data_i[NCH-1:0];
      inv_o <= wr_data_i[INV_BIT];
    end
  end
endmodule

// File: rtl/ckey_chan_cmp.sv
module ckey_chan_cmp #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] val_i,
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  input  logic          en_i,
  output logic          hit_o
);
  // a disabled channel never vetoes the key
  assign hit_o = !en_i || ((val_i >= lo_i) && (val_i <= hi_i));
endmodule

// File: rtl/ckey_switch.sv
module ckey_switch
  import ckey_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 8,
  parameter int PW = 24,
  parameter logic [AW-1:0] BASE = 8'h30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic [CW-1:0] red_i,
  input  logic [CW-1:0] grn_i,
  input  logic [CW-1:0] blu_i,
  input  logic [CW-1:0] ovl_i,
  input  logic [PW-1:0] dir_pix_i,
  input  logic [PW-1:0] alt_pix_i,
  output logic [PW-1:0] pix_o,
  output logic          alt_sel_o
);
  logic [NCH-1:0][CW-1:0] win_lo, win_hi, ch_val;
  logic [NCH-1:0]         ch_en, ch_hit;
  logic                   key_inv, sel_d;

  ckey_regs #(.CW(CW), .AW(AW), .BASE(BASE)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .lo_o      (win_lo),
    .hi_o      (win_hi),
    .en_o      (ch_en),
    .inv_o     (key_inv)
  );

  assign ch_val[CH_RED] = red_i;
  assign ch_val[CH_GRN] = grn_i;
  assign ch_val[CH_BLU] = blu_i;
  assign ch_val[CH_OVL] = ovl_i;

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    ckey_chan_cmp #(.CW(CW)) u_cmp (
      .val_i (ch_val[c]),
      .lo_i  (win_lo[c]),
      .hi_i  (win_hi[c]),
      .en_i  (ch_en[c]),
      .hit_o (ch_hit[c])
    );
  end

  // no enabled comparator forces the direct source, polarity notwithstanding
  assign sel_d = (|ch_en) && ((&ch_hit) ^ key_inv);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o     <= '0;
      alt_sel_o <= 1'b0;
    end else begin
      pix_o     <= sel_d ? alt_pix_i : dir_pix_i;
      alt_sel_o <= sel_d;
    end
  end
endmodule

// File: rtl/ckey_switch_chk.sv
module ckey_switch_chk #(
  parameter int PW = 24,
  parameter int NCH = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [PW-1:0] dir_pix_i,
  input logic [PW-1:0] alt_pix_i,
  input logic [PW-1:0] pix_o,
  input logic          alt_sel_o,
  input logic [NCH-1:0] en_i,
  input logic          inv_i
);
  logic pv;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv <= 1'b0;
    else         pv <= 1'b1;
  end

  a_r1_reset_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pv |-> (!alt_sel_o && pix_o == '0));

  a_r5_no_enable_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv && $past(en_i) == '0) |-> !alt_sel_o);

  a_r7_alt_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv && alt_sel_o) |-> pix_o == $past(alt_pix_i));

  a_r7_dir_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv && !alt_sel_o) |-> pix_o == $past(dir_pix_i));

  // R6: with invert on, a selection needs at least one enabled channel
  a_r6_inv_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv && alt_sel_o && $past(inv_i)) |-> $past(en_i) != '0);
endmodule

bind ckey_switch ckey_switch_chk #(.PW(PW), .NCH(ckey_pkg::NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dir_pix_i (dir_pix_i),
  .alt_pix_i (alt_pix_i),
  .pix_o     (pix_o),
  .alt_sel_o (alt_sel_o),
  .en_i      (ch_en),
  .inv_i     (key_inv)
);

// File: tb/sim_ckey_switch.sv
module sim_ckey_switch;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 24;

  logic clk = 0, rst_ni = 0;
  logic wr_en_i = 0;
  logic [7:0] wr_addr_i = 0, wr_data_i = 0;
  logic [7:0] red_i = 0, grn_i = 0, blu_i = 0, ovl_i = 0;
  logic [PW-1:0] dir_pix_i = 0, alt_pix_i = 0, pix_o;
  logic alt_sel_o;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_lo[4], m_hi[4];
  logic [3:0] m_en;
  logic m_inv;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckey_switch u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
    .ovl_i(ovl_i), .dir_pix_i(dir_pix_i), .alt_pix_i(alt_pix_i),
    .pix_o(pix_o), .alt_sel_o(alt_sel_o)
  );

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_sel(input logic [7:0] r, g, b, o);
    logic [7:0] v[4];
    bit all;
    v[0] = r; v[1] = g; v[2] = b; v[3] = o;
    all = 1;
    for (int c = 0; c < 4; c++)
      if (m_en[c] && !(v[c] >= m_lo[c] && v[c] <= m_hi[c])) all = 0;
    return (m_en != 0) && (all ^ m_inv);
  endfunction

  task automatic model_write(input logic [7:0] a, d);
    if (a >= 8'h30 && a <= 8'h37) begin
      if (a[0]) m_hi[(a - 8'h30) >> 1] = d;
      else      m_lo[(a - 8'h30) >> 1] = d;
    end else if (a == 8'h38) begin
      m_en = d[3:0];
      m_inv = d[4];
    end
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic step(input logic [7:0] r, g, b, o, input logic [PW-1:0] dp, ap,
                      input bit we, input logic [7:0] wa, wd, input string tag);
    bit es;
    red_i = r; grn_i = g; blu_i = b; ovl_i = o;
    dir_pix_i = dp; alt_pix_i = ap;
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    es = exp_sel(r, g, b, o);
    @(posedge clk);
    if (we) model_write(wa, wd);
    @(negedge clk);
    wr_en_i = 0;
    check({tag, " sel"}, PW'(alt_sel_o), PW'(es));
    check({tag, " pix"}, pix_o, es ? ap : dp);
  endtask

  task automatic wr(input logic [7:0] a, d);
    step(0, 0, 0, 0, 24'h0a0a0a, 24'h0b0b0b, 1, a, d, "R2 write");
  endtask

  task automatic px(input logic [7:0] r, g, b, o, input string tag);
    step(r, g, b, o, 24'h123456, 24'habcdef, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 4; c++) begin m_lo[c] = 0; m_hi[c] = 0; end
    m_en = 0; m_inv = 0;
    repeat (3) @(negedge clk);
    check("R1 reset sel", PW'(alt_sel_o), 0);
    check("R1 reset pix", pix_o, 0);
    rst_ni = 1;
    @(negedge clk);
    check("R1 after release pix", pix_o, 0);

    // R1: all-zero windows with no enables: zero pixel never selects
    px(0, 0, 0, 0, "R1 regs zero");
    wr(8'h30, 8'h10); wr(8'h31, 8'h20);
    px(8'h15, 0, 0, 0, "R5 none enabled");
    wr(8'h38, 8'h10);
    px(8'h15, 0, 0, 0, "R5 invert only");
    wr(8'h38, 8'h01);
    px(8'h10, 0, 0, 0, "R3 low bound");
    px(8'h20, 0, 0, 0, "R3 high bound");
    px(8'h0f, 0, 0, 0, "R3 below low");
    px(8'h21, 0, 0, 0, "R3 above high");
    for (int i = 0; i < 6; i++) px(8'h0e + 8'(i * 3), 0, 0, 0, "R8 per pixel");
    wr(8'h32, 8'h80); wr(8'h33, 8'h80); wr(8'h38, 8'h03);
    px(8'h15, 8'h80, 0, 0, "R4 both hit");
    px(8'h15, 8'h81, 0, 0, "R4 green miss");
    px(8'h40, 8'h80, 0, 0, "R4 red miss");
    wr(8'h34, 8'h50); wr(8'h35, 8'h40); wr(8'h38, 8'h04);
    px(0, 0, 8'h48, 0, "R3 empty window");
    px(0, 0, 8'h50, 0, "R3 empty window lo");
    wr(8'h36, 8'h05); wr(8'h37, 8'h07); wr(8'h38, 8'h08);
    px(0, 0, 0, 8'h06, "R10 overlay hit");
    px(0, 0, 0, 8'h08, "R10 overlay miss");
    wr(8'h38, 8'h18);
    px(0, 0, 0, 8'h06, "R6 inverted hit");
    px(0, 0, 0, 8'h09, "R6 inverted miss");
    wr(8'h39, 8'hff); wr(8'h2f, 8'hff);
    px(0, 0, 0, 8'h06, "R2 stray address");
    px(0, 0, 0, 8'h09, "R2 stray address");
    step(0, 0, 0, 8'h09, 24'h111111, 24'h222222, 1, 8'h38, 8'h08, "R9 same cycle");
    px(0, 0, 0, 8'h09, "R9 next pixel");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] v[4];
      int ch;
      bit we;
      logic [7:0] wa, wd;
      for (int c = 0; c < 4; c++) begin
        if ($urandom_range(1, 0) == 1 && m_lo[c] <= m_hi[c])
          v[c] = 8'($urandom_range(int'(m_hi[c]), int'(m_lo[c])));
        else
          v[c] = 8'($urandom);
      end
      we = ($urandom_range(9, 0) == 0);
      ch = $urandom_range(8, 0);
      wa = 8'h30 + 8'(ch);
      wd = 8'($urandom);
      if (ch == 8) wd = {3'b0, wd[4:0]};
      step(v[0], v[1], v[2], v[3], PW'($urandom), PW'($urandom), we, wa, wd, "R4 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule